// File: doc/BRIEF.md
# Chopped Sinc3 Decimator with Offset-Cancelling Averager

This block sits behind a single-bit sigma-delta modulator. Each clock of the modulator rate delivers one bit. The block first undoes the chopping of the analog chain by XOR-ing each bit with its own chop phase. It maps the result to +1 or -1 and feeds it to a third-order sinc decimator. The decimation ratio N is eight times an 8-bit filter word.

The chop phase is held for three decimation periods, which is the full length of the sinc3 impulse response. One filter result therefore depends only on samples taken under a single chop phase. After each such period the chop phase flips, and the new result is added to the previous one and halved. A constant offset picked up before the demodulating XOR enters the two results with opposite signs, so the averaging step cancels it. The averaged value is scaled to a signed 16-bit word and announced by a one-cycle strobe. The same chop phase is driven out so that the input multiplexer can swap its inputs.

A change of the filter word restarts the whole chain. The old ratio's history is never mixed into a result made at the new ratio.

Top module: `chop_sinc3_decim`

## Requirements
- R1: While rst_n is low, data_out is 0, data_valid is 0 and chop_phase is 0.
- R2: An accepted sample counts as +1 when mod_bit XOR chop_phase is 1 and as -1 when it is 0, where chop_phase is the value it holds in the same cycle.
- R3: The effective filter word is sf_word when sf_word is 13 or more and 13 otherwise. The decimation ratio N is 8 times the effective word, and strobes after the first are exactly 3N cycles apart.
- R4: chop_phase toggles once every 3N accepted samples. The filter result for one chop period is the sum of the period's last 3N-2 samples, weighted by the convolution of three length-N rectangular windows, with the newest sample at delay 0.
- R5: At the end of each chop period after the first one since a restart, data_out is loaded with (current result + previous result) arithmetically shifted right by 3k-14, where k is the smallest integer with N <= 2^k.
- R6: A shifted value above 32767 gives 32767, and one below -32768 gives -32768.
- R7: data_valid is high for exactly one cycle, in the cycle after the last sample of a chop period, and only when a previous result exists.
- R8: In any cycle where sf_word differs from its value in the previous accepted cycle, that cycle's sample is discarded, all filter and averaging history is cleared and chop_phase returns to 0. The first strobe then comes 6N cycles later. A change that keeps the same effective word also restarts.
- R9: A mod_bit held constant for two or more whole chop periods gives data_out 0 at the following strobes.
- R10: data_out keeps its value in every cycle where data_valid is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Modulator-rate clock, one bitstream sample per rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| mod_bit | input | 1 | Modulator output bit |
| sf_word | input | 8 | Filter word that sets the decimation ratio |
| data_out | output | 16 | Averaged, scaled signed result |
| data_valid | output | 1 | One-cycle strobe for a new data_out |
| chop_phase | output | 1 | Chop phase for the input multiplexer and the demodulating XOR |

## Verification
A bad integrator or differentiator value never shows up on its own. It appears in the result at the end of the current chop period, at most 3N cycles later. Because of the averaging, it also corrupts the next strobe. A wrong period counter shows up sooner: it moves the chop_phase edge or the strobe by at least one cycle, and the per-cycle comparison catches that. A restart that leaves history behind produces an early strobe or a wrong first value within 6N cycles of the filter-word change.

// File: rtl/csd_pkg.sv
package csd_pkg;

   // smallest r such that v <= 2**r
   function automatic int unsigned ceil_log2(input int unsigned v);
      int unsigned r;
      r = 0;
      for (int i = 0; i < 31; i++) begin
         if ((32'd1 << i) < v) r = i + 1;
      end
      return r;
   endfunction

endpackage

// File: rtl/csd_rate_ctrl.sv
module csd_rate_ctrl #(
   parameter int SF_W   = 8,
   parameter int SF_MIN = 13,
   parameter int ORDER  = 3,
   parameter int OUT_W  = 16,
   parameter int SH_W   = 6
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [SF_W-1:0] sf_word,
   output logic            restart,
   output logic            dec_tick,
   output logic            period_end,
   output logic            chop_phase,
   output logic [SH_W-1:0] shr
);
   localparam int N_W  = SF_W + 3;
   localparam int PH_W = (ORDER > 1) ? $clog2(ORDER) : 1;

   logic [SF_W-1:0] sf_q, sf_eff;
   logic [N_W-1:0]  n_dec, dec_cnt;
   logic [PH_W-1:0] ph_cnt;
   logic            ph_last, chop_q, tick_raw;
   int unsigned     k_bits;

   assign restart  = (sf_word != sf_q);
   assign sf_eff   = (sf_q < SF_W'(SF_MIN)) ? SF_W'(SF_MIN) : sf_q;
   assign n_dec    = {sf_eff, 3'b000};
   assign tick_raw = (dec_cnt == n_dec - N_W'(1));
   assign ph_last  = (ph_cnt == PH_W'(ORDER - 1));

   assign dec_tick   = tick_raw && !restart;
   assign period_end = tick_raw && ph_last && !restart;
   assign chop_phase = chop_q;

   always_comb begin
      k_bits = csd_pkg::ceil_log2(32'(n_dec));
      shr    = SH_W'(ORDER * int'(k_bits) - (OUT_W - 2));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sf_q    <= '0;
         dec_cnt <= '0;
         ph_cnt  <= '0;
         chop_q  <= 1'b0;
      end else if (restart) begin
         sf_q    <= sf_word;
         dec_cnt <= '0;
         ph_cnt  <= '0;
         chop_q  <= 1'b0;
      end else if (tick_raw) begin
         dec_cnt <= '0;
         if (ph_last) begin
            ph_cnt <= '0;
            chop_q <= ~chop_q;
         end else begin
            ph_cnt <= ph_cnt + PH_W'(1);
         end
      end else begin
         dec_cnt <= dec_cnt + N_W'(1);
      end
   end

   // R3: the decimation counter never reaches the ratio
   a_r3_cnt_range: assert property (@(posedge clk) disable iff (!rst_n)
      dec_cnt < n_dec);

   // R4: the phase counter stays below the filter order
   a_r4_phase_range: assert property (@(posedge clk) disable iff (!rst_n)
      int'(ph_cnt) < ORDER);

   // R4: the chop phase moves only at a period end or a restart
   a_r4_chop_edge: assert property (@(posedge clk) disable iff (!rst_n)
      (!period_end && !restart) |=> $stable(chop_q));
endmodule

// File: rtl/csd_sinc3_core.sv
module csd_sinc3_core #(
   parameter int ORDER = 3,
   parameter int ACC_W = 34
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    clear,
   input  logic                    bit_pos,
   input  logic                    dec_tick,
   output logic signed [ACC_W-1:0] y_now
);
   logic signed [ACC_W-1:0] x_val;
   logic signed [ACC_W-1:0] ichain [ORDER+1];
   logic signed [ACC_W-1:0] cchain [ORDER+1];

   assign x_val     = bit_pos ? ACC_W'(1) : {ACC_W{1'b1}};
   assign ichain[0] = x_val;
   assign cchain[0] = ichain[ORDER];
   assign y_now     = cchain[ORDER];

   for (genvar g = 0; g < ORDER; g++) begin : g_integ
      logic signed [ACC_W-1:0] acc_q;
      assign ichain[g+1] = acc_q + ichain[g];
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)     acc_q <= '0;
         else if (clear) acc_q <= '0;
         else            acc_q <= ichain[g+1];
      end
      if (g == 0) begin : g_chk
         // R2: each accepted sample moves the first stage by exactly one step
         a_r2_unit_step: assert property (@(posedge clk) disable iff (!rst_n)
            !clear |=> ((acc_q - $past(acc_q)) == ACC_W'(1) ||
                        (acc_q - $past(acc_q)) == {ACC_W{1'b1}}));
      end
   end

   for (genvar g = 0; g < ORDER; g++) begin : g_comb
      logic signed [ACC_W-1:0] dly_q;
      assign cchain[g+1] = cchain[g] - dly_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)        dly_q <= '0;
         else if (clear)    dly_q <= '0;
         else if (dec_tick) dly_q <= cchain[g];
      end
   end
endmodule

// File: rtl/csd_chop_avg.sv
module csd_chop_avg #(
   parameter int ACC_W = 34,
   parameter int OUT_W = 16,
   parameter int SH_W  = 6
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    clear,
   input  logic                    period_end,
   input  logic signed [ACC_W-1:0] y_now,
   input  logic [SH_W-1:0]         shr,
   output logic [OUT_W-1:0]        data_out,
   output logic                    data_valid
);
   localparam logic signed [ACC_W:0] SAT_HI = (ACC_W+1)'(2**(OUT_W-1) - 1);
   localparam logic signed [ACC_W:0] SAT_LO = -SAT_HI - 1;

   logic signed [ACC_W-1:0] prev_q;
   logic                    have_prev;
   logic signed [ACC_W:0]   sum_w, scaled;
   logic [OUT_W-1:0]        sat_v;

   assign sum_w  = $signed({y_now[ACC_W-1], y_now}) + $signed({prev_q[ACC_W-1], prev_q});
   assign scaled = sum_w >>> shr;

   always_comb begin
      if (scaled > SAT_HI)      sat_v = SAT_HI[OUT_W-1:0];
      else if (scaled < SAT_LO) sat_v = SAT_LO[OUT_W-1:0];
      else                      sat_v = scaled[OUT_W-1:0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q     <= '0;
         have_prev  <= 1'b0;
         data_out   <= '0;
         data_valid <= 1'b0;
      end else if (clear) begin
         prev_q     <= '0;
         have_prev  <= 1'b0;
         data_valid <= 1'b0;
      end else if (period_end) begin
         prev_q     <= y_now;
         have_prev  <= 1'b1;
         data_valid <= have_prev;
         if (have_prev) data_out <= sat_v;
      end else begin
         data_valid <= 1'b0;
      end
   end

   // R7: the strobe never lasts two cycles
   a_r7_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      data_valid |=> !data_valid);

   // R7: a strobe follows a period end
   a_r7_after_end: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(data_valid) |-> $past(period_end));
endmodule

// File: rtl/chop_sinc3_decim.sv
module chop_sinc3_decim #(
   parameter int SF_W   = 8,
   parameter int SF_MIN = 13,
   parameter int ORDER  = 3,
   parameter int OUT_W  = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             mod_bit,
   input  logic [SF_W-1:0]  sf_word,
   output logic [OUT_W-1:0] data_out,
   output logic             data_valid,
   output logic             chop_phase
);
   localparam int MAX_N = 8 * (2**SF_W - 1);
   localparam int ACC_W = ORDER * $clog2(MAX_N) + 1;
   localparam int SH_W  = $clog2(ORDER * $clog2(MAX_N) + 2);

   if (SF_MIN < 1) begin : g_bad_min
      $error("SF_MIN must be positive");
   end
   if (ORDER * $clog2(8 * SF_MIN) < OUT_W - 1) begin : g_bad_shift
      $error("SF_MIN too small for the output width");
   end
   if (ACC_W > 62) begin : g_bad_acc
      $error("accumulator too wide");
   end

   logic                    restart, dec_tick, period_end, bit_pos;
   logic [SH_W-1:0]         shr;
   logic signed [ACC_W-1:0] y_now;

   assign bit_pos = mod_bit ^ chop_phase;

   csd_rate_ctrl #(.SF_W(SF_W), .SF_MIN(SF_MIN), .ORDER(ORDER), .OUT_W(OUT_W), .SH_W(SH_W))
   u_rate (
      .clk(clk), .rst_n(rst_n), .sf_word(sf_word), .restart(restart),
      .dec_tick(dec_tick), .period_end(period_end), .chop_phase(chop_phase), .shr(shr)
   );

   csd_sinc3_core #(.ORDER(ORDER), .ACC_W(ACC_W)) u_core (
      .clk(clk), .rst_n(rst_n), .clear(restart), .bit_pos(bit_pos),
      .dec_tick(dec_tick), .y_now(y_now)
   );

   csd_chop_avg #(.ACC_W(ACC_W), .OUT_W(OUT_W), .SH_W(SH_W)) u_avg (
      .clk(clk), .rst_n(rst_n), .clear(restart), .period_end(period_end),
      .y_now(y_now), .shr(shr), .data_out(data_out), .data_valid(data_valid)
   );

   // R4: a strobe coincides with a flip of the chop phase
   a_r4_flip_on_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(data_valid) |-> (chop_phase != $past(chop_phase)));

   // R8: a restart clears the strobe and the chop phase
   a_r8_restart_clear: assert property (@(posedge clk) disable iff (!rst_n)
      restart |=> (!data_valid && !chop_phase));

   // R10: the output word holds between strobes
   a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !data_valid |-> $stable(data_out));
endmodule

// File: tb/chop_sinc3_decim_tb_top.sv
module chop_sinc3_decim_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        mod_bit = 1'b0;
   logic [7:0]  sf_word = 8'd16;
   logic [15:0] data_out;
   logic        data_valid;
   logic        chop_phase;

   int n_tests = 0;
   int n_fail  = 0;
   int mode    = 0;
   bit done    = 1'b0;

   always #2 clk = ~clk;

   chop_sinc3_decim dut_i (
      .clk(clk), .rst_n(rst_n), .mod_bit(mod_bit), .sf_word(sf_word),
      .data_out(data_out), .data_valid(data_valid), .chop_phase(chop_phase)
   );

   task automatic check(input string req, input longint act, input longint exp);
      n_tests++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
      end
   endtask

   // reference model
   longint q1[$], q2[$], q3[$];
   longint s1, s2, s3, prev_y;
   int     m_sf, dcnt, pcnt;
   bit     have_prev, m_chop, m_valid;
   logic [15:0] m_data;

   function automatic int eff_n(input int sf);
      return 8 * ((sf < 13) ? 13 : sf);
   endfunction

   function automatic int shift_of(input int n);
      int k = 0;
      while ((1 << k) < n) k++;
      return 3 * k - 14;
   endfunction

   task automatic model_clear();
      q1.delete(); q2.delete(); q3.delete();
      s1 = 0; s2 = 0; s3 = 0; prev_y = 0;
      dcnt = 0; pcnt = 0; have_prev = 0; m_chop = 0; m_valid = 0;
   endtask

   always @(posedge clk) begin
      if (!rst_n) begin
         model_clear();
         m_sf = 0; m_data = 16'd0;
      end else if (int'(sf_word) != m_sf) begin
         m_sf = int'(sf_word);
         model_clear();
      end else begin
         int     n;
         longint x, v;
         n = eff_n(m_sf);
         x = (mod_bit ^ m_chop) ? 1 : -1;
         q1.push_back(x);  s1 += x;  if (q1.size() > n) s1 -= q1.pop_front();
         q2.push_back(s1); s2 += s1; if (q2.size() > n) s2 -= q2.pop_front();
         q3.push_back(s2); s3 += s2; if (q3.size() > n) s3 -= q3.pop_front();
         m_valid = 0;
         dcnt++;
         if (dcnt == n) begin
            dcnt = 0;
            pcnt++;
            if (pcnt == 3) begin
               pcnt = 0;
               if (have_prev) begin
                  v = (s3 + prev_y) >>> shift_of(n);
                  if (v > 32767) v = 32767;
                  if (v < -32768) v = -32768;
                  m_data  = 16'(v);
                  m_valid = 1;
               end
               prev_y = s3;
               have_prev = 1;
               m_chop = ~m_chop;
            end
         end
      end
   end

   // per-cycle comparison and observation
   int          cyc = 0, vcount = 0, last_vcyc = -1, last_gap = 0;
   logic [15:0] last_dut = 16'd0;

   always @(negedge clk) begin
      cyc++;
      if (rst_n) begin
         check("R7 strobe timing", longint'(data_valid), longint'(m_valid));
         check("R4 chop phase", longint'(chop_phase), longint'(m_chop));
         if (data_valid)
            check("R5 averaged value", longint'($signed(data_out)), longint'($signed(m_data)));
         else
            check("R10 hold", longint'($signed(data_out)), longint'($signed(m_data)));
         if (data_valid) begin
            vcount++;
            last_dut = data_out;
            if (last_vcyc >= 0) last_gap = cyc - last_vcyc;
            last_vcyc = cyc;
         end
      end
   end

   // modulator stand-in
   always @(negedge clk) begin
      case (mode)
         0:       mod_bit <= 1'b1;
         1:       mod_bit <= ~chop_phase;
         2:       mod_bit <= chop_phase;
         default: mod_bit <= 1'($urandom);
      endcase
   end

   task automatic new_sf(input logic [7:0] v);
      @(negedge clk);
      sf_word = v;
      last_vcyc = -1;
      last_gap = 0;
   endtask

   initial begin
      int snap;
      repeat (5) @(negedge clk);
      check("R1 data_out in reset", longint'(data_out), 0);
      check("R1 data_valid in reset", longint'(data_valid), 0);
      check("R1 chop_phase in reset", longint'(chop_phase), 0);
      rst_n = 1'b1;

      // R9: constant bitstream, N=128
      mode = 0;
      repeat (2000) @(negedge clk);
      check("R9 offset cancelled", longint'($signed(last_dut)), 0);
      check("R9 strobes seen", longint'(vcount > 2), 1);

      // R2 and R6: positive full scale
      mode = 1;
      repeat (1600) @(negedge clk);
      check("R6 positive clamp (R2 mapping)", longint'($signed(last_dut)), 32767);

      // R6: negative full scale
      mode = 2;
      repeat (1600) @(negedge clk);
      check("R6 negative limit", longint'($signed(last_dut)), -32768);

      mode = 3;
      repeat (3000) @(negedge clk);
      check("R3 gap N=128", longint'(last_gap), 384);

      // R3 clamp and R8 restart: word 5 acts as 13
      new_sf(8'd5);
      snap = vcount;
      @(negedge clk);
      check("R8 chop back to 0", longint'(chop_phase), 0);
      repeat (6 * 104 - 2) @(negedge clk);
      check("R8 no early strobe", longint'(vcount), longint'(snap));
      repeat (1500) @(negedge clk);
      check("R3 clamped gap", longint'(last_gap), 312);

      // R8: same effective word still restarts
      new_sf(8'd7);
      snap = vcount;
      repeat (6 * 104 - 1) @(negedge clk);
      check("R8 restart on equal clamp", longint'(vcount), longint'(snap));
      repeat (1000) @(negedge clk);

      // large ratio
      new_sf(8'd200);
      repeat (6 * 1600 + 3 * 4800 + 10) @(negedge clk);
      check("R3 gap N=1600", longint'(last_gap), 4800);

      new_sf(8'd255);
      mode = 1;
      repeat (6 * 2040 + 6120 + 10) @(negedge clk);
      check("R5 top ratio full scale", longint'($signed(last_dut)),
            ((2 * longint'(2040) * 2040 * 2040) >>> 19));

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end
endmodule